// File: doc/BRIEF.md
# Serial Peripheral Byte Mover

This block moves bytes between a set of serial peripherals and memory with no help from the processor. Every peripheral owns two channels: one that carries its received bytes into memory, and one that fetches bytes from memory for it to send. Software loads a channel with a 32-bit memory address and a 16-bit byte count through that peripheral's own register window. The channel then serves the peripheral's byte requests by itself, until the count reaches zero and its end-of-transfer interrupt goes high.

Channel number `c` serves peripheral `c/2`. Even channels receive and odd channels transmit. All channels share one single-beat memory port. When several channels request at once, the lowest channel number wins. After every byte the engine arbitrates again. Each byte takes three cycles at least: a grant cycle, the memory access (which holds until acknowledged), and a completion cycle in which the peripheral sees its strobe.

Top module: `perxfer_ctrl`

## Requirements
- R1: After reset, every pointer and count reads zero. All `eot_irq` bits are low. `mem_req`, `rx_ack` and `tx_valid` are low.
- R2: A write with `cfg_wr` high lands in the window of peripheral `cfg_periph`, at the register that `cfg_off` selects. `cfg_off` = 0 is the receive pointer, 1 the receive count, 2 the transmit pointer and 3 the transmit count. `cfg_rdata` shows the addressed register in the same cycle. A count takes the low 16 bits of the written value and reads back zero-extended.
- R3: Each byte moved raises the channel's pointer by one and lowers its count by one.
- R4: When a transfer takes a channel's count to zero, `eot_irq[c]` goes high. Channel `c = 2*p` is the receive channel of peripheral `p` and `c = 2*p+1` is its transmit channel.
- R5: A receive channel writes `rx_data` byte `p` to memory at its pointer, with `mem_we` = 1. A transmit channel reads memory with `mem_we` = 0 and presents the byte on `tx_data`. `rx_ack[p]` or `tx_valid[p]` pulses for one cycle, in the cycle after the one in which `mem_ack` completed the access.
- R6: A channel whose count is zero ignores its peripheral's request. No memory access and no strobe come from it.
- R7: Pending channels are granted one memory access at a time, lowest channel number first. Arbitration is repeated after every byte, so a channel that stays ready drains fully before a higher-numbered one starts.
- R8: `eot_irq[c]` stays high until software writes a nonzero count to that channel. Writing a zero count leaves it unchanged.
- R9: If a software write and a byte completion hit the same channel in the same cycle, the written register takes the written value. The other register still steps. A count written in that cycle does not set `eot_irq`.
- R10: Once raised, `mem_req` holds, with `mem_addr`, `mem_we` and `mem_wdata` stable, until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_periph | input | PSEL_W | Peripheral window select |
| cfg_off | input | 2 | Register select within the window |
| cfg_wdata | input | ADDR_W | Write data |
| cfg_rdata | output | ADDR_W | Read data of the addressed register |
| rx_req | input | NUM_PERIPH | Receive byte ready, one per peripheral, held until `rx_ack` |
| rx_data | input | 8*NUM_PERIPH | Received bytes, byte `p` for peripheral `p` |
| rx_ack | output | NUM_PERIPH | Received byte stored |
| tx_req | input | NUM_PERIPH | Transmit byte wanted, held until `tx_valid` |
| tx_data | output | 8 | Byte for the strobed transmitter |
| tx_valid | output | NUM_PERIPH | `tx_data` is valid for this peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes at this edge |
| eot_irq | output | 2*NUM_PERIPH | Level end-of-transfer interrupt per channel |

## Verification
Two things can land on the same channel registers in one cycle: a software register write and the pointer and count update of a completing byte. The bench provokes this from its memory model. At the moment the model raises `mem_ack` for an active channel, it also drives a write to that channel's count (and, in a second case, its pointer). After the transfer drains, the bench checks from the readback and the interrupt that the written value took effect while the other register still stepped. The second such pair, several channels requesting in one cycle, is judged by the order of the peripheral strobes across random rounds.

// File: rtl/perxfer_pkg.sv
package perxfer_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_DONE = 2'd2
   } xfer_state_e;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/perxfer_arb.sv
module perxfer_arb #(
   parameter int N     = 8,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   if (N < 1) begin : g_bad_n
      $error("perxfer_arb: N must be at least 1");
   end

   assign any = |req;

   if (N == 1) begin : g_single
      assign idx = '0;
   end else begin : g_prio
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/perxfer_chan.sv
module perxfer_chan #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ptr,
   input  logic              wr_cnt,
   input  logic [ADDR_W-1:0] wdata,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr,
   output logic [CNT_W-1:0]  cnt,
   output logic              eot
);
   logic [CNT_W-1:0] new_cnt;
   logic             cnt_live;

   assign new_cnt  = wdata[CNT_W-1:0];
   assign cnt_live = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
         cnt <= '0;
         eot <= 1'b0;
      end else begin
         if (wr_ptr)    ptr <= wdata;
         else if (step) ptr <= ptr + 1'b1;

         if (wr_cnt) begin
            cnt <= new_cnt;
            if (new_cnt != '0) eot <= 1'b0;
         end else if (step && cnt_live) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) eot <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/perxfer_ctrl.sv
module perxfer_ctrl
   import perxfer_pkg::*;
#(
   parameter int  NUM_PERIPH = 4,
   parameter int  ADDR_W     = 32,
   parameter int  CNT_W      = 16,
   localparam int PSEL_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1,
   localparam int NUM_CH     = 2 * NUM_PERIPH
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_wr,
   input  logic [PSEL_W-1:0]          cfg_periph,
   input  logic [1:0]                 cfg_off,
   input  logic [ADDR_W-1:0]          cfg_wdata,
   output logic [ADDR_W-1:0]          cfg_rdata,
   input  logic [NUM_PERIPH-1:0]      rx_req,
   input  logic [8*NUM_PERIPH-1:0]    rx_data,
   output logic [NUM_PERIPH-1:0]      rx_ack,
   input  logic [NUM_PERIPH-1:0]      tx_req,
   output logic [7:0]                 tx_data,
   output logic [NUM_PERIPH-1:0]      tx_valid,
   output logic                       mem_req,
   output logic                       mem_we,
   output logic [ADDR_W-1:0]          mem_addr,
   output logic [7:0]                 mem_wdata,
   input  logic [7:0]                 mem_rdata,
   input  logic                       mem_ack,
   output logic [NUM_CH-1:0]          eot_irq
);
   localparam int CH_W = $clog2(NUM_CH);

   if (NUM_PERIPH < 1) begin : g_bad_np
      $error("perxfer_ctrl: NUM_PERIPH must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > ADDR_W) begin : g_bad_cnt
      $error("perxfer_ctrl: CNT_W must lie in 1..ADDR_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("perxfer_ctrl: ADDR_W must be at least 8");
   end

   logic [NUM_CH-1:0][ADDR_W-1:0] ptr_all;
   logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all;
   logic [NUM_CH-1:0]             wr_ptr_v, wr_cnt_v, step_v, live_req;

   xfer_state_e          state;
   logic [CH_W-1:0]      cur, win;
   logic                 win_any;
   logic [PSEL_W-1:0]    cur_p;
   logic [BYTE_W-1:0]    tx_byte;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int   P     = c / 2;
      localparam logic IS_TX = (c % 2) == 1;
      logic src_req;

      assign src_req     = IS_TX ? tx_req[P] : rx_req[P];
      assign live_req[c] = src_req && (cnt_all[c] != '0);
      assign wr_ptr_v[c] = cfg_wr && (cfg_periph == PSEL_W'(P)) && (cfg_off == {IS_TX, 1'b0});
      assign wr_cnt_v[c] = cfg_wr && (cfg_periph == PSEL_W'(P)) && (cfg_off == {IS_TX, 1'b1});

      perxfer_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_ptr (wr_ptr_v[c]),
         .wr_cnt (wr_cnt_v[c]),
         .wdata  (cfg_wdata),
         .step   (step_v[c]),
         .ptr    (ptr_all[c]),
         .cnt    (cnt_all[c]),
         .eot    (eot_irq[c])
      );
   end

   perxfer_arb #(.N(NUM_CH), .IDX_W(CH_W)) u_arb (
      .req (live_req),
      .any (win_any),
      .idx (win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cur     <= '0;
         tx_byte <= '0;
      end else begin
         case (state)
            ST_IDLE: if (win_any) begin
               cur   <= win;
               state <= ST_XFER;
            end
            ST_XFER: if (mem_ack) begin
               if (cur[0]) tx_byte <= mem_rdata;
               state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cur_p     = PSEL_W'(cur >> 1);
   assign step_v    = (state == ST_XFER && mem_ack) ? (NUM_CH'(1) << cur) : '0;
   assign mem_req   = (state == ST_XFER);
   assign mem_we    = !cur[0];
   assign mem_addr  = ptr_all[cur];
   assign mem_wdata = rx_data[int'(cur_p) * 8 +: 8];
   assign tx_data   = tx_byte;

   for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_strobe
      assign rx_ack[p]   = (state == ST_DONE) && !cur[0] && (cur_p == PSEL_W'(p));
      assign tx_valid[p] = (state == ST_DONE) &&  cur[0] && (cur_p == PSEL_W'(p));
   end

   logic [CH_W-1:0] rd_ch;
   assign rd_ch = CH_W'({cfg_periph, cfg_off[1]});

   always_comb begin
      cfg_rdata = '0;
      if (int'(rd_ch) < NUM_CH) begin
         if (cfg_off[0]) cfg_rdata = ADDR_W'(cnt_all[rd_ch]);
         else            cfg_rdata = ptr_all[rd_ch];
      end
   end
endmodule

// File: rtl/perxfer_ctrl_chk.sv
module perxfer_ctrl_chk #(
   parameter int NUM_PERIPH = 4,
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int NUM_CH     = 2 * NUM_PERIPH
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         cfg_wdata,
   input logic [NUM_CH-1:0]         wr_ptr_v,
   input logic [NUM_CH-1:0]         wr_cnt_v,
   input logic [NUM_CH-1:0]         step_v,
   input logic [NUM_CH-1:0][ADDR_W-1:0] ptr_all,
   input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all,
   input logic [NUM_CH-1:0]         eot_irq,
   input logic [NUM_PERIPH-1:0]     rx_ack,
   input logic [NUM_PERIPH-1:0]     tx_valid,
   input logic                      mem_req,
   input logic                      mem_ack,
   input logic                      mem_we,
   input logic [ADDR_W-1:0]         mem_addr,
   input logic [7:0]                mem_wdata
);
   assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_ack, tx_valid}));

   assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
         step_v[c] && !wr_ptr_v[c] |=> ptr_all[c] == $past(ptr_all[c]) + 1'b1);

      assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
         step_v[c] && !wr_cnt_v[c] && cnt_all[c] != '0 |=> cnt_all[c] == $past(cnt_all[c]) - 1'b1);

      assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
         wr_cnt_v[c] |=> cnt_all[c] == $past(cfg_wdata[CNT_W-1:0]));

      assert_eot_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
         step_v[c] && !wr_cnt_v[c] && cnt_all[c] == CNT_W'(1) |=> eot_irq[c]);

      assert_eot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         eot_irq[c] && !(wr_cnt_v[c] && cfg_wdata[CNT_W-1:0] != '0) |=> eot_irq[c]);

      assert_idle_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_all[c] == '0 && !wr_cnt_v[c] |=> cnt_all[c] == '0);
   end
endmodule

bind perxfer_ctrl perxfer_ctrl_chk #(
   .NUM_PERIPH (NUM_PERIPH),
   .ADDR_W     (ADDR_W),
   .CNT_W      (CNT_W),
   .NUM_CH     (NUM_CH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wdata (cfg_wdata),
   .wr_ptr_v  (wr_ptr_v),
   .wr_cnt_v  (wr_cnt_v),
   .step_v    (step_v),
   .ptr_all   (ptr_all),
   .cnt_all   (cnt_all),
   .eot_irq   (eot_irq),
   .rx_ack    (rx_ack),
   .tx_valid  (tx_valid),
   .mem_req   (mem_req),
   .mem_ack   (mem_ack),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata)
);

// File: tb/perxfer_ctrl_tb.sv
module perxfer_ctrl_tb;
   localparam int NP = 4;
   localparam int NC = 2 * NP;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [1:0] cfg_periph = '0, cfg_off = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic [NP-1:0] rx_req = '0, tx_req = '0, rx_ack, tx_valid;
   logic [8*NP-1:0] rx_data = '0;
   logic [7:0] tx_data, mem_wdata, mem_rdata = '0;
   logic mem_req, mem_we, mem_ack = 1'b0;
   logic [31:0] mem_addr;
   logic [NC-1:0] eot_irq;

   always #4 clk = ~clk;

   perxfer_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_periph(cfg_periph), .cfg_off(cfg_off),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_req(rx_req), .rx_data(rx_data),
      .rx_ack(rx_ack), .tx_req(tx_req), .tx_data(tx_data), .tx_valid(tx_valid),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .eot_irq(eot_irq)
   );

   int checks = 0, fails = 0, cyc = 0;
   logic [7:0] bmem [0:1023];
   int rx_left [NP], tx_left [NP], rx_idx [NP], tx_idx [NP];
   logic [7:0] txcap [NP][0:63];
   int svc_log [0:255];
   int svc_n = 0, req_cycles = 0;
   int mem_fixed = 0, mem_delay = 0, wait_cnt = 0;
   logic [31:0] addr_hold;
   int coll_arm = 0, coll_p = 0, coll_off = 0;
   logic [31:0] coll_val;
   int coll_clear = 0;
   logic [7:0] salt = 8'h3C;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] rx_byte(input int p, input int i);
      return 8'(p * 37 + i * 11 + int'(salt));
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         for (int p = 0; p < NP; p++) begin
            if (rx_ack[p]) begin
               chk(mem_ack == 1'b1, "R5 rx_ack one cycle after mem_ack", rx_ack[p], 1);
               svc_log[svc_n] = 2 * p; svc_n++;
               rx_left[p]--; rx_idx[p]++;
            end
            if (tx_valid[p]) begin
               chk(mem_ack == 1'b1, "R5 tx_valid one cycle after mem_ack", tx_valid[p], 1);
               txcap[p][tx_idx[p]] = tx_data;
               svc_log[svc_n] = 2 * p + 1; svc_n++;
               tx_left[p]--; tx_idx[p]++;
            end
         end
         if (coll_clear != 0) begin cfg_wr = 1'b0; coll_clear = 0; end
         mem_ack = 1'b0;
         if (mem_req) begin
            req_cycles++;
            if (wait_cnt == 0) addr_hold = mem_addr;
            else chk(mem_addr == addr_hold, "R10 address held while waiting", mem_addr, addr_hold);
            if (wait_cnt >= mem_delay) begin
               mem_ack = 1'b1;
               if (mem_we) bmem[mem_addr[9:0]] = mem_wdata;
               else mem_rdata = bmem[mem_addr[9:0]];
               wait_cnt = 0;
               mem_delay = (mem_fixed >= 0) ? mem_fixed : int'($urandom % 3);
               if (coll_arm != 0) begin
                  cfg_wr = 1'b1; cfg_periph = 2'(coll_p); cfg_off = 2'(coll_off);
                  cfg_wdata = coll_val; coll_arm = 0; coll_clear = 1;
               end
            end else wait_cnt++;
         end
         for (int p = 0; p < NP; p++) begin
            rx_req[p] = rx_left[p] > 0;
            tx_req[p] = tx_left[p] > 0;
            rx_data[p*8 +: 8] = rx_byte(p, rx_idx[p]);
         end
      end
   end

   task automatic wr(input int p, input int off, input logic [31:0] v);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_periph = 2'(p); cfg_off = 2'(off); cfg_wdata = v;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input int p, input int off, output logic [31:0] v);
      @(negedge clk);
      cfg_periph = 2'(p); cfg_off = 2'(off);
      #1 v = cfg_rdata;
   endtask

   task automatic drain();
      int tot;
      do begin
         @(negedge clk);
         tot = 0;
         for (int p = 0; p < NP; p++) tot += rx_left[p] + tx_left[p];
      end while (tot != 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      int n [NC];
      int base [NC];
      int ghost, k;
      for (int i = 0; i < 1024; i++) bmem[i] = 8'(i * 7 + 1);
      for (int p = 0; p < NP; p++) begin rx_left[p] = 0; tx_left[p] = 0; rx_idx[p] = 0; tx_idx[p] = 0; end
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(eot_irq == '0, "R1 eot after reset", eot_irq, 0);
      chk(!mem_req && rx_ack == '0 && tx_valid == '0, "R1 idle outputs", {mem_req, rx_ack, tx_valid}, 0);
      for (int p = 0; p < NP; p++)
         for (int o = 0; o < 4; o++) begin
            rd(p, o, v);
            chk(v == 0, "R1 register reset", v, 0);
         end

      // R2: map, readback, count truncation
      wr(3, 2, 32'hDEADBEEF); rd(3, 2, v);
      chk(v == 32'hDEADBEEF, "R2 tx pointer window 3", v, 32'hDEADBEEF);
      wr(1, 0, 32'h00000ABC); rd(1, 0, v);
      chk(v == 32'h00000ABC, "R2 rx pointer window 1", v, 32'hABC);
      wr(3, 3, 32'h00012345); rd(3, 3, v);
      chk(v == 32'h00002345, "R2 count truncated to 16 bits", v, 32'h2345);
      rd(3, 1, v);
      chk(v == 0, "R2 neighbour count untouched", v, 0);
      wr(3, 3, 0);

      // R6: zero count ignores request
      wr(1, 1, 0);
      k = req_cycles;
      rx_left[1] = 3;
      repeat (20) @(negedge clk);
      chk(req_cycles == k, "R6 no memory access at zero count", req_cycles, k);
      chk(rx_idx[1] == 0, "R6 no rx_ack at zero count", rx_idx[1], 0);
      rx_left[1] = 0;
      repeat (2) @(negedge clk);

      // R3 R4 R5 R6 R7 R8: random rounds
      mem_fixed = -1;
      for (int r = 0; r < 12; r++) begin
         salt = 8'($urandom);
         svc_n = 0;
         ghost = -1;
         for (int c = 0; c < NC; c++) begin
            n[c] = int'($urandom % 7);
            base[c] = c * 128 + int'($urandom % 32);
            if (n[c] == 0 && ghost < 0) ghost = c;
         end
         if (ghost < 0) begin ghost = int'($urandom % NC); n[ghost] = 0; end
         for (int c = 0; c < NC; c++) begin
            if (c % 2 == 1)
               for (int i = 0; i < n[c]; i++) bmem[base[c] + i] = 8'($urandom);
            wr(c / 2, (c % 2) * 2, 32'(base[c]));
            wr(c / 2, (c % 2) * 2 + 1, 32'(n[c]));
         end
         for (int c = 0; c < NC; c++)
            if (n[c] > 0) chk(eot_irq[c] == 1'b0, "R8 nonzero count write clears eot", eot_irq[c], 0);
         for (int p = 0; p < NP; p++) begin rx_idx[p] = 0; tx_idx[p] = 0; end
         @(negedge clk);
         for (int p = 0; p < NP; p++) begin
            rx_left[p] = n[2*p];
            tx_left[p] = n[2*p+1];
         end
         if (ghost % 2 == 0) rx_left[ghost/2] = 2; else tx_left[ghost/2] = 2;
         // wait until the real channels drain
         do begin
            @(negedge clk);
            k = 0;
            for (int c = 0; c < NC; c++)
               if (c != ghost) k += (c % 2 == 0) ? rx_left[c/2] : tx_left[c/2];
         end while (k != 0);
         repeat (10) @(negedge clk);
         chk(((ghost % 2 == 0) ? rx_idx[ghost/2] : tx_idx[ghost/2]) == 0,
             "R6 zero-count channel never served", ghost, 0);
         if (ghost % 2 == 0) rx_left[ghost/2] = 0; else tx_left[ghost/2] = 0;
         // R7: strict order, lowest channel drained first
         k = 0;
         for (int c = 0; c < NC; c++)
            for (int i = 0; i < n[c]; i++) begin
               chk(k < svc_n && svc_log[k] == c, "R7 service order", (k < svc_n) ? svc_log[k] : -1, c);
               k++;
            end
         chk(svc_n == k, "R7 service count", svc_n, k);
         for (int c = 0; c < NC; c++) begin
            for (int i = 0; i < n[c]; i++) begin
               if (c % 2 == 0)
                  chk(bmem[base[c] + i] == rx_byte(c/2, i), "R5 rx byte in memory", bmem[base[c] + i], rx_byte(c/2, i));
               else
                  chk(txcap[c/2][i] == bmem[base[c] + i], "R5 tx byte delivered", txcap[c/2][i], bmem[base[c] + i]);
            end
            rd(c / 2, (c % 2) * 2, v);
            chk(v == 32'(base[c] + n[c]), "R3 pointer advanced", v, base[c] + n[c]);
            rd(c / 2, (c % 2) * 2 + 1, v);
            chk(v == 0, "R3 count drained", v, 0);
            if (n[c] > 0) chk(eot_irq[c] == 1'b1, "R4 eot raised at zero", eot_irq[c], 1);
         end
      end

      // R8: zero write keeps eot, nonzero clears it
      wr(2, 0, 32'h10); wr(2, 1, 1);
      mem_fixed = 0; rx_idx[2] = 0; rx_left[2] = 1;
      drain();
      chk(eot_irq[4] == 1'b1, "R4 single byte raises eot", eot_irq[4], 1);
      wr(2, 1, 0);
      chk(eot_irq[4] == 1'b1, "R8 zero count write keeps eot", eot_irq[4], 1);
      wr(2, 1, 7);
      chk(eot_irq[4] == 1'b0, "R8 nonzero count write clears eot", eot_irq[4], 0);
      wr(2, 1, 0);

      // R9: count write coincides with a completion on ch0
      mem_fixed = 1; mem_delay = 1;
      wr(0, 0, 32'h300); wr(0, 1, 2);
      coll_p = 0; coll_off = 1; coll_val = 32'd5; coll_arm = 1;
      rx_idx[0] = 0; rx_left[0] = 2;
      drain();
      rd(0, 1, v);
      chk(v == 4, "R9 written count wins then steps once", v, 4);
      rd(0, 0, v);
      chk(v == 32'h302, "R9 pointer still steps", v, 32'h302);
      chk(eot_irq[0] == 1'b0, "R9 no eot after overwrite", eot_irq[0], 0);
      chk(bmem[10'h301] == rx_byte(0, 1), "R5 rx second byte", bmem[10'h301], rx_byte(0, 1));
      wr(0, 1, 0);

      // R9: pointer write coincides with the last completion on ch1
      bmem[10'h380] = 8'h5A;
      wr(0, 2, 32'h380); wr(0, 3, 1);
      coll_p = 0; coll_off = 2; coll_val = 32'h3A0; coll_arm = 1;
      tx_idx[0] = 0; tx_left[0] = 1;
      drain();
      rd(0, 2, v);
      chk(v == 32'h3A0, "R9 written pointer wins", v, 32'h3A0);
      rd(0, 3, v);
      chk(v == 0, "R9 count still steps", v, 0);
      chk(eot_irq[1] == 1'b1, "R4 eot with pointer overwrite", eot_irq[1], 1);
      chk(txcap[0][0] == 8'h5A, "R5 tx byte on collision", txcap[0][0], 8'h5A);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule